// File: doc/BRIEF.md
# Reset Configuration Byte Fetch Sequencer

After reset is released, this block reads two configuration bytes through a separate bus-cycle engine and holds them in configuration registers. It then lets the processor core leave reset and names the address of its first instruction. Each read goes out as a single-cycle request. The request carries an address, a bus width, an address/data multiplexing choice and a wait-state count. The block then waits for a completion strobe from the bus engine, which returns the byte with it. The bus engine handles pin timing and any extension by a ready signal.

The first byte is always read with fixed, conservative settings. These are an 8-bit multiplexed bus with three wait states. The settings for the second read come from fields of the first byte. When the sequence ends, the first byte is also copied into the bus-control register of chip-select 0.

A source-select pin is sampled once, as the sequence starts. A 1 on this pin sends both reads to internal ROM; a 0 sends them to external memory. The captured value stays on a request flag for the whole sequence.

The controller moves through six named states:
- IDLE: entered at reset. It always moves to FETCH0 on the first clock after reset and captures the source pin on that edge.
- FETCH0: issues the first request, then moves to WAIT0.
- WAIT0: stays until the completion strobe arrives, then latches byte 0 and moves to FETCH1.
- FETCH1: issues the second request, then moves to WAIT1.
- WAIT1: stays until the strobe arrives, then latches byte 1 and the chip-select 0 copy and moves to DONE.
- DONE: is absorbing until the next reset. It holds the core release high.

Top module: `cfg_fetch_seq`

## Requirements
- R1: While reset is held, req_valid, core_release, cfg0, cfg1, cs0_ctl and boot_pc are all 0.
- R2: On the first clock after reset, a single one-cycle request is issued. It goes to address FF2018H with req_waits=3, req_wide=0 (8-bit) and req_demux=0 (multiplexed).
- R3: One cycle after byte 0 is latched, a single one-cycle request is issued to FF201AH. Its req_waits is byte0[5:4], its req_demux is byte0[3] and its req_wide is byte0[1].
- R4: cfg0 takes bus_rdata on the edge where bus_done is seen in WAIT0. cfg1 takes bus_rdata on the edge where bus_done is seen in WAIT1.
- R5: req_internal equals the value of src_internal at the first clock after reset. Later changes of src_internal have no effect on it.
- R6: cs0_ctl stays 0 until the sequence completes. It then holds the byte 0 value.
- R7: core_release rises on the same edge that cfg1 is latched. From then on boot_pc reads FF2080H; before that it reads 0.
- R8: After completion, further bus_done pulses, bus_rdata values and src_internal changes leave cfg0, cfg1, cs0_ctl and core_release unchanged, and no request is issued.
- R9: While a wait state sees no bus_done, the block issues no request and holds the core in reset, however long that takes.
- R10: A bus_done that coincides with a request cycle is ignored and latches nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_internal | input | 1 | 1 = read from internal ROM, 0 = external memory |
| bus_done | input | 1 | Bus engine completion strobe |
| bus_rdata | input | 8 | Byte returned with bus_done |
| req_valid | output | 1 | One-cycle request strobe |
| req_addr | output | 24 | Request address |
| req_wide | output | 1 | 1 = 16-bit bus, 0 = 8-bit |
| req_demux | output | 1 | 1 = demultiplexed, 0 = multiplexed |
| req_waits | output | 2 | Minimum wait states |
| req_internal | output | 1 | Captured source select |
| cfg0 | output | 8 | Configuration register 0 |
| cfg1 | output | 8 | Configuration register 1 |
| cs0_ctl | output | 8 | Chip-select 0 bus-control register |
| core_release | output | 1 | Lets the core out of reset |
| boot_pc | output | 24 | First instruction address once released |

## Verification
The bench builds the block with its default parameters: 24-bit addresses, 8-bit bytes, three wait states for the first read, and the three fixed addresses. With these settings every wait-state count and width/multiplex combination for the second read can come from a random byte 0.

Bus latencies from zero to six cycles cover both the immediate response and long stalls. Strobes placed in request cycles and after completion reach the cases where input must be ignored.

// File: rtl/cfg_fetch_pkg.sv
package cfg_fetch_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH0,
        ST_WAIT0,
        ST_FETCH1,
        ST_WAIT1,
        ST_DONE
    } seq_state_e;

    // field positions inside byte 0 that steer the second read
    localparam int WS_W      = 2;
    localparam int WS_LO     = 4;
    localparam int DEMUX_BIT = 3;
    localparam int WIDE_BIT  = 1;
endpackage

// File: rtl/cfg_fetch_fsm.sv
module cfg_fetch_fsm
    import cfg_fetch_pkg::*;
#(
    parameter int          ADDR_W      = 24,
    parameter logic [23:0] CFG0_ADDR   = 24'hFF2018,
    parameter logic [23:0] CFG1_ADDR   = 24'hFF201A,
    parameter int          FIRST_WAITS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_internal,
    input  logic              bus_done,
    input  logic [WS_W-1:0]   b0_waits,
    input  logic              b0_demux,
    input  logic              b0_wide,
    output logic              req_valid,
    output logic [ADDR_W-1:0] req_addr,
    output logic              req_wide,
    output logic              req_demux,
    output logic [WS_W-1:0]   req_waits,
    output logic              req_internal,
    output logic              load0,
    output logic              load1,
    output logic              done
);
    localparam logic [WS_W-1:0] FIRST_WS = WS_W'(FIRST_WAITS);

    seq_state_e state_q, state_d;
    logic       internal_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 internal_q <= 1'b0;
        else if (state_q == ST_IDLE) internal_q <= src_internal;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = ST_FETCH0;
            ST_FETCH0: state_d = ST_WAIT0;
            ST_WAIT0:  if (bus_done) state_d = ST_FETCH1;
            ST_FETCH1: state_d = ST_WAIT1;
            ST_WAIT1:  if (bus_done) state_d = ST_DONE;
            ST_DONE:   state_d = ST_DONE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        req_valid = 1'b0;
        req_addr  = '0;
        req_wide  = 1'b0;
        req_demux = 1'b0;
        req_waits = '0;
        load0     = 1'b0;
        load1     = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            ST_FETCH0: begin
                req_valid = 1'b1;
                req_addr  = CFG0_ADDR[ADDR_W-1:0];
                req_waits = FIRST_WS;
            end
            ST_WAIT0: load0 = bus_done;
            ST_FETCH1: begin
                req_valid = 1'b1;
                req_addr  = CFG1_ADDR[ADDR_W-1:0];
                req_waits = b0_waits;
                req_demux = b0_demux;
                req_wide  = b0_wide;
            end
            ST_WAIT1: load1 = bus_done;
            ST_DONE:  done  = 1'b1;
            default: ;
        endcase
    end

    assign req_internal = internal_q;

    // R2
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> !req_valid);

    // R5
    src_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> $stable(req_internal));

    // R7
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(load1));

    // R9
    wait_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load0 || load1) |=> !done || $past(load1));
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load0,
    input  logic              load1,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] cfg0,
    output logic [BYTE_W-1:0] cfg1,
    output logic [BYTE_W-1:0] cs0_ctl
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg0    <= '0;
            cfg1    <= '0;
            cs0_ctl <= '0;
        end else begin
            if (load0) cfg0 <= wdata;
            if (load1) begin
                cfg1    <= wdata;
                cs0_ctl <= cfg0;
            end
        end
    end

    // R4
    single_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(load0 && load1));
endmodule

// File: rtl/cfg_fetch_seq.sv
module cfg_fetch_seq
    import cfg_fetch_pkg::*;
#(
    parameter int          ADDR_W      = 24,
    parameter int          BYTE_W      = 8,
    parameter logic [23:0] CFG0_ADDR   = 24'hFF2018,
    parameter logic [23:0] CFG1_ADDR   = 24'hFF201A,
    parameter logic [23:0] BOOT_ADDR   = 24'hFF2080,
    parameter int          FIRST_WAITS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_internal,
    input  logic              bus_done,
    input  logic [BYTE_W-1:0] bus_rdata,
    output logic              req_valid,
    output logic [ADDR_W-1:0] req_addr,
    output logic              req_wide,
    output logic              req_demux,
    output logic [WS_W-1:0]   req_waits,
    output logic              req_internal,
    output logic [BYTE_W-1:0] cfg0,
    output logic [BYTE_W-1:0] cfg1,
    output logic [BYTE_W-1:0] cs0_ctl,
    output logic              core_release,
    output logic [ADDR_W-1:0] boot_pc
);
    logic load0, load1, done;

    cfg_fetch_fsm #(
        .ADDR_W(ADDR_W), .CFG0_ADDR(CFG0_ADDR), .CFG1_ADDR(CFG1_ADDR),
        .FIRST_WAITS(FIRST_WAITS)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .src_internal(src_internal),
        .bus_done(bus_done),
        .b0_waits(cfg0[WS_LO +: WS_W]), .b0_demux(cfg0[DEMUX_BIT]),
        .b0_wide(cfg0[WIDE_BIT]),
        .req_valid(req_valid), .req_addr(req_addr), .req_wide(req_wide),
        .req_demux(req_demux), .req_waits(req_waits),
        .req_internal(req_internal), .load0(load0), .load1(load1),
        .done(done)
    );

    cfg_reg_bank #(.BYTE_W(BYTE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .load0(load0), .load1(load1),
        .wdata(bus_rdata), .cfg0(cfg0), .cfg1(cfg1), .cs0_ctl(cs0_ctl)
    );

    assign core_release = done;
    assign boot_pc      = done ? BOOT_ADDR[ADDR_W-1:0] : '0;

    // R3
    second_params_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr == CFG1_ADDR[ADDR_W-1:0]) |->
        (req_waits == cfg0[WS_LO +: WS_W] && req_demux == cfg0[DEMUX_BIT]
         && req_wide == cfg0[WIDE_BIT]));

    // R6
    cs0_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_release |-> (cs0_ctl == cfg0));

    // R8
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_release |=> ($stable(cfg0) && $stable(cfg1) && $stable(cs0_ctl)
                          && core_release && !req_valid));
endmodule

// File: tb/cfg_fetch_seq_tb.sv
module cfg_fetch_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        src_internal = 1'b0;
    logic        bus_done = 1'b0;
    logic [7:0]  bus_rdata = '0;
    logic        req_valid, req_wide, req_demux, req_internal, core_release;
    logic [23:0] req_addr, boot_pc;
    logic [1:0]  req_waits;
    logic [7:0]  cfg0, cfg1, cs0_ctl;

    int total = 0;
    int fails = 0;

    always #5 clk = ~clk;

    cfg_fetch_seq u_dut (
        .clk(clk), .rst_n(rst_n), .src_internal(src_internal),
        .bus_done(bus_done), .bus_rdata(bus_rdata),
        .req_valid(req_valid), .req_addr(req_addr), .req_wide(req_wide),
        .req_demux(req_demux), .req_waits(req_waits),
        .req_internal(req_internal), .cfg0(cfg0), .cfg1(cfg1),
        .cs0_ctl(cs0_ctl), .core_release(core_release), .boot_pc(boot_pc)
    );

    task automatic chk(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_waits(input logic [7:0] b);
        return b[5:4];
    endfunction

    task automatic run_seq(input logic src, input logic [7:0] b0,
                           input logic [7:0] b1, input int lat0,
                           input int lat1, input logic early);
        rst_n = 1'b0; bus_done = 1'b0; src_internal = src;
        repeat (2) @(negedge clk);
        chk("R1 req_valid", req_valid, 0);
        chk("R1 release", core_release, 0);
        chk("R1 cfg", {cfg0, cfg1, cs0_ctl}, 0);
        chk("R1 boot_pc", boot_pc, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 valid", req_valid, 1);
        chk("R2 addr", req_addr, 24'hFF2018);
        chk("R2 params", {req_waits, req_wide, req_demux}, {2'd3, 1'b0, 1'b0});
        chk("R5 captured", req_internal, src);
        src_internal = ~src;
        if (early) begin bus_done = 1'b1; bus_rdata = ~b0; end
        @(negedge clk);
        bus_done = 1'b0;
        chk("R2 single pulse", req_valid, 0);
        chk("R10 ignored", cfg0, 0);
        for (int i = 0; i < lat0; i++) begin
            @(negedge clk);
            chk("R9 quiet0", {req_valid, core_release}, 0);
        end
        bus_done = 1'b1; bus_rdata = b0;
        @(negedge clk);
        bus_done = 1'b0;
        chk("R4 cfg0", cfg0, b0);
        chk("R3 valid", req_valid, 1);
        chk("R3 addr", req_addr, 24'hFF201A);
        chk("R3 params", {req_waits, req_demux, req_wide},
            {exp_waits(b0), b0[3], b0[1]});
        chk("R5 held", req_internal, src);
        chk("R6 before", cs0_ctl, 0);
        if (early) begin bus_done = 1'b1; bus_rdata = ~b1; end
        @(negedge clk);
        bus_done = 1'b0;
        chk("R10 ignored1", {cfg1, core_release}, 0);
        for (int i = 0; i < lat1; i++) begin
            @(negedge clk);
            chk("R9 quiet1", {req_valid, core_release}, 0);
        end
        bus_done = 1'b1; bus_rdata = b1;
        @(negedge clk);
        bus_done = 1'b0;
        chk("R4 cfg1", cfg1, b1);
        chk("R7 release", core_release, 1);
        chk("R7 boot_pc", boot_pc, 24'hFF2080);
        chk("R6 copy", cs0_ctl, b0);
        chk("R5 end", req_internal, src);
        for (int i = 0; i < 3; i++) begin
            bus_done = 1'b1; bus_rdata = 8'($urandom);
            src_internal = ~src_internal;
            @(negedge clk);
            chk("R8 frozen", {cfg0, cfg1, cs0_ctl}, {b0, b1, b0});
            chk("R8 no req", {req_valid, core_release}, 2'b01);
        end
        bus_done = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        // directed corners
        run_seq(1'b0, 8'hFF, 8'h00, 0, 0, 1'b0);
        run_seq(1'b1, 8'h00, 8'hFF, 6, 6, 1'b1);
        run_seq(1'b1, 8'h2A, 8'hC5, 1, 0, 1'b1);
        for (int n = 0; n < 25; n++)
            run_seq(1'($urandom), 8'($urandom), 8'($urandom),
                    int'($urandom % 7), int'($urandom % 7), 1'($urandom));
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule